// File: doc/BRIEF.md
# I2S Audio Transmitter with Sample FIFO

This block is a transmit-only audio serializer that runs as the clock master. Samples arrive one word per write strobe into a 32-entry transmit FIFO. A serializer turns them into a bit clock, a word-select clock and a serial data line. The bit clock comes from the system clock through a programmable 9-bit divider. Every frame has two 32-bit slots, so the bit clock always runs at 64 times the sample rate, whatever the sample width.

Framing can be standard I2S or MSB-justified. The stream can be stereo, or mono with a choice of routing to the slots. Left and right can be exchanged, and the right slot can be sent first. A request output tells an upstream feeder that the FIFO has fallen to a programmable fill point. A sticky flag records every frame that started without enough data. On such a frame the block sends silence, or the previous frame again, depending on a configuration input.

Configuration inputs are expected to change only while `en_i` is low. The divider may be written at any time.

Top module: `i2s_tx`

## Requirements
- R1: The bit clock half-period is `div+1` system clocks, so its period is `2*(div+1)`. The divider resets to 1 and a write through `div_wr_i` of a value up to 511 takes effect.
- R2: A divider write with a value above 511 leaves the divider unchanged.
- R3: While `en_i` is low, `bclk_o` is low. `lrclk_o` and `sdata_o` change only on a falling edge of `bclk_o`. A frame is 64 bit clocks long and is made of two 32-bit slots. The first falling edge after enable starts a frame.
- R4: The width code `width_i` gives 0=8, 1=16, 2=18, 3=20 and 4=24 bits; codes 5 to 7 also give 24. The sample is taken from the low bits of the written word and is sent MSB first from the start of its slot. All remaining slot bits are 0.
- R5: With `msbj_i`=1, `lrclk_o` is high for the left slot and the MSB goes out in the first bit of the slot. With `msbj_i`=0 (I2S), `lrclk_o` is low for the left slot and the MSB goes out one bit clock after the `lrclk_o` edge.
- R6: In stereo mode (`stereo_i`=1), each frame takes two FIFO entries: the older one is left and the newer one is right. `swap_i`=1 exchanges the left and right data. `right_first_i`=1 sends the right slot in the first half of the frame.
- R7: In mono mode, each frame takes one entry. `mono_route_i` sends it to both slots (0 or 3), to the right slot only (1) or to the left slot only (2), and the other slot carries zeros. Swap is applied after routing.
- R8: The FIFO holds 32 entries and `fifo_level_o` gives its fill count. A write while full is dropped.
- R9: `tx_req_o` is high exactly when `fifo_level_o <= 2*thresh_i+1`.
- R10: When a frame starts with fewer entries than the mode needs, no entry is taken and `underrun_o` sets. It stays set until `underrun_clr_i`; a new underrun in the same cycle wins over the clear.
- R11: On an underrun frame, `last_sample_i`=1 resends the previous frame's slots and `last_sample_i`=0 sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the bit clock and serializer |
| div_wr_i | input | 1 | Divider write strobe |
| div_val_i | input | 10 | Divider value to write |
| msbj_i | input | 1 | 1 = MSB-justified, 0 = I2S framing |
| stereo_i | input | 1 | 1 = stereo, 0 = mono |
| mono_route_i | input | 2 | Mono slot routing |
| right_first_i | input | 1 | Send right slot first |
| swap_i | input | 1 | Exchange left and right data |
| width_i | input | 3 | Sample width code |
| thresh_i | input | 4 | Request threshold field |
| last_sample_i | input | 1 | Repeat previous frame on underrun |
| wr_i | input | 1 | Sample write strobe |
| wr_data_i | input | 24 | Sample word |
| underrun_clr_i | input | 1 | Clear underrun flag |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word-select clock |
| sdata_o | output | 1 | Serial data |
| fifo_level_o | output | 6 | FIFO fill count |
| tx_req_o | output | 1 | Data request |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The serial stream is tried with several patterns, and each one separates a different effect.

- A mono sample routed to both slots and a right-only routing under I2S framing separate slot placement from the one-bit delay and from the word-select polarity.
- A left-only routing with swap, and another with right-first, show that swap acts after routing and that slot order is independent of swap.
- A stereo run of 32 distinct 24-bit words, with one extra write into the full FIFO, shows the pairing order and that the dropped word never appears. The repeat frame then separates repeating the previous frame from sending silence.
- A stereo frame start with a single entry left separates "no pop on underrun" from a partial pop: that lone entry must come out intact in a later mono frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned SLOT_W = 32;
  localparam int unsigned SMP_W  = 24;

  typedef enum logic [1:0] {
    ROUTE_BOTH  = 2'd0,
    ROUTE_RIGHT = 2'd1,
    ROUTE_LEFT  = 2'd2
  } route_e;

  function automatic logic [5:0] width_of(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd16;
      3'd2:    return 6'd18;
      3'd3:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  // sample sits in low bits of the word; result is MSB-aligned in the slot
  function automatic logic [SLOT_W-1:0] place(input logic [SMP_W-1:0] s,
                                               input logic [2:0] code);
    logic [5:0]        w;
    logic [SLOT_W-1:0] m;
    w = width_of(code);
    m = {{(SLOT_W-SMP_W){1'b0}}, s} & ~({SLOT_W{1'b1}} << w);
    return m << (6'(SLOT_W) - w);
  endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
// DEPTH must be a power of two
module i2s_tx_fifo #(
  parameter  int unsigned DEPTH = 32,
  parameter  int unsigned DW    = 24,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    pop_i,
  output logic [DW-1:0] head_o,
  output logic [DW-1:0] next_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] level_q;
  logic          push_ok;

  assign push_ok = push_i && (level_q < LW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      rd_q    <= rd_q + AW'(pop_i);
      level_q <= level_q + LW'(push_ok) - LW'(pop_i);
    end
  end

  assign head_o  = mem[rd_q];
  assign next_o  = mem[rd_q + AW'(1)];
  assign level_o = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH)); // R8
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LW'(DEPTH)) && push_i && (pop_i == 2'd0) |=> level_q == LW'(DEPTH)); // R8
  AST_POP_WITHIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LW'(pop_i) <= level_q); // R10
endmodule

// File: rtl/i2s_tx_bclk.sv
module i2s_tx_bclk #(
  parameter int unsigned DIV_W   = 9,
  parameter int unsigned DIV_RST = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           div_wr_i,
  input  logic [DIV_W:0] div_val_i,
  output logic           bclk_o,
  output logic           fall_o
);
  localparam logic [DIV_W:0] DIV_MAX = {1'b0, {DIV_W{1'b1}}};

  logic [DIV_W-1:0] div_q, cnt_q;
  logic             bclk_q, edge_hit;

  assign edge_hit = en_i && (cnt_q >= div_q);
  assign fall_o   = edge_hit && bclk_q;
  assign bclk_o   = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(DIV_RST);
    end else if (div_wr_i && (div_val_i <= DIV_MAX)) begin
      div_q <= div_val_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (edge_hit) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  AST_DIV_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr_i && (div_val_i > DIV_MAX) |=> $stable(div_q)); // R2
  AST_BCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bclk_o); // R3
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift
  import i2s_tx_pkg::*;
#(
  parameter  int unsigned LW      = 6,
  localparam int unsigned FRAME_W = 2 * SLOT_W,
  localparam int unsigned BW      = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fall_i,
  input  logic             msbj_i,
  input  logic             stereo_i,
  input  logic [1:0]       route_i,
  input  logic             right_first_i,
  input  logic             swap_i,
  input  logic [2:0]       width_i,
  input  logic             last_sample_i,
  input  logic [LW-1:0]    level_i,
  input  logic [SMP_W-1:0] head_i,
  input  logic [SMP_W-1:0] next_i,
  input  logic             underrun_clr_i,
  output logic [1:0]       pop_o,
  output logic             lrclk_o,
  output logic             sdata_o,
  output logic             underrun_o
);
  logic [BW-1:0]      bit_q, bit_d;
  logic [FRAME_W-1:0] frame_q, frame_d, fresh;
  logic [SLOT_W-1:0]  s0, s1, l, r;
  logic [1:0]         need;
  logic               wrap, avail, starve, is_left, lr_d, sd_d, lr_q, sd_q, unr_q;

  always_comb begin
    need  = stereo_i ? 2'd2 : 2'd1;
    avail = level_i >= LW'(need);
    wrap  = fall_i && (bit_q == BW'(FRAME_W - 1));
    s0    = place(head_i, width_i);
    s1    = place(next_i, width_i);
    if (stereo_i) begin
      l = s0;
      r = s1;
    end else begin
      case (route_e'(route_i))
        ROUTE_RIGHT: begin l = '0; r = s0; end
        ROUTE_LEFT:  begin l = s0; r = '0; end
        default:     begin l = s0; r = s0; end
      endcase
    end
    if (swap_i) {l, r} = {r, l};
    fresh = right_first_i ? {r, l} : {l, r};

    frame_d = frame_q;
    pop_o   = 2'd0;
    starve  = 1'b0;
    if (wrap) begin
      if (avail) begin
        frame_d = fresh;
        pop_o   = need;
      end else begin
        starve = 1'b1;
        if (!last_sample_i) frame_d = '0;
      end
    end

    bit_d   = bit_q + BW'(1);
    is_left = !bit_d[BW-1] ^ right_first_i;
    lr_d    = ~(is_left ^ msbj_i);
    // I2S: one bit late; previous frame's final bit is always padding
    if (msbj_i)              sd_d = frame_d[BW'(FRAME_W - 1) - bit_d];
    else if (bit_d == '0)    sd_d = 1'b0;
    else                     sd_d = frame_d[BW'(0) - bit_d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '1;
      frame_q <= '0;
      lr_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else if (!en_i) begin
      bit_q   <= '1;
    end else if (fall_i) begin
      bit_q   <= bit_d;
      frame_q <= frame_d;
      lr_q    <= lr_d;
      sd_q    <= sd_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             unr_q <= 1'b0;
    else if (starve)         unr_q <= 1'b1;
    else if (underrun_clr_i) unr_q <= 1'b0;
  end

  assign lrclk_o    = lr_q;
  assign sdata_o    = sd_q;
  assign underrun_o = unr_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !underrun_clr_i |=> underrun_o); // R10
  AST_STARVE_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o != 2'd0) |-> LW'(pop_o) <= level_i); // R10
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  parameter  int unsigned DIV_W = 9,
  parameter  int unsigned TH_W  = 4,
  localparam int unsigned LW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             div_wr_i,
  input  logic [DIV_W:0]   div_val_i,
  input  logic             msbj_i,
  input  logic             stereo_i,
  input  logic [1:0]       mono_route_i,
  input  logic             right_first_i,
  input  logic             swap_i,
  input  logic [2:0]       width_i,
  input  logic [TH_W-1:0]  thresh_i,
  input  logic             last_sample_i,
  input  logic             wr_i,
  input  logic [SMP_W-1:0] wr_data_i,
  input  logic             underrun_clr_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             sdata_o,
  output logic [LW-1:0]    fifo_level_o,
  output logic             tx_req_o,
  output logic             underrun_o
);
  logic [SMP_W-1:0] head, nxt;
  logic [1:0]       pop;
  logic             fall;

  i2s_tx_fifo #(.DEPTH(DEPTH), .DW(SMP_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (wr_i),
    .data_i (wr_data_i),
    .pop_i  (pop),
    .head_o (head),
    .next_o (nxt),
    .level_o(fifo_level_o)
  );

  i2s_tx_bclk #(.DIV_W(DIV_W)) u_bclk (
    .clk_i, .rst_ni, .en_i, .div_wr_i, .div_val_i,
    .bclk_o,
    .fall_o(fall)
  );

  i2s_tx_shift #(.LW(LW)) u_shift (
    .clk_i, .rst_ni, .en_i,
    .fall_i        (fall),
    .msbj_i, .stereo_i,
    .route_i       (mono_route_i),
    .right_first_i, .swap_i, .width_i, .last_sample_i,
    .level_i       (fifo_level_o),
    .head_i        (head),
    .next_i        (nxt),
    .underrun_clr_i,
    .pop_o         (pop),
    .lrclk_o, .sdata_o, .underrun_o
  );

  assign tx_req_o = fifo_level_o <= LW'({thresh_i, 1'b1});

  AST_LRCLK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(bclk_o)); // R3
  AST_SDATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(bclk_o)); // R3
endmodule

// File: tb/i2s_tx_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0, div_wr = 1'b0, msbj = 1'b1, stereo = 1'b0;
  logic [9:0]  div_val = '0;
  logic [1:0]  route = 2'd0;
  logic        rf = 1'b0, swap = 1'b0, last = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [2:0]  width = 3'd1;
  logic [3:0]  thresh = 4'd15;
  logic [23:0] wr_data = '0;
  logic        bclk, lrclk, sdata, tx_req, underrun;
  logic [5:0]  level;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] q_d[$], q_l[$];
  string       q_r[$];

  always #10 clk = ~clk;

  i2s_tx dut_i (
    .clk_i(clk), .rst_ni, .en_i(en), .div_wr_i(div_wr), .div_val_i(div_val),
    .msbj_i(msbj), .stereo_i(stereo), .mono_route_i(route), .right_first_i(rf),
    .swap_i(swap), .width_i(width), .thresh_i(thresh), .last_sample_i(last),
    .wr_i(wr), .wr_data_i(wr_data), .underrun_clr_i(clr),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata), .fifo_level_o(level),
    .tx_req_o(tx_req), .underrun_o(underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_slot(input logic [23:0] s, input logic [2:0] code);
    int w;
    logic [31:0] t;
    case (code)
      3'd0: w = 8;  3'd1: w = 16; 3'd2: w = 18; 3'd3: w = 20;
      default: w = 24;
    endcase
    t = {8'h00, s};
    return t << (32 - w);
  endfunction

  // expected frame from current configuration
  task automatic want(input logic [23:0] a, input logic [23:0] b, input bit zero,
                      input string req);
    logic [31:0] l, r, t, first, second;
    logic [63:0] raw, d, lv;
    if (zero) begin
      l = '0; r = '0;
    end else if (stereo) begin
      l = mk_slot(a, width); r = mk_slot(b, width);
    end else begin
      l = mk_slot(a, width); r = l;
      if (route == 2'd1) l = '0;
      if (route == 2'd2) r = '0;
    end
    if (swap) begin t = l; l = r; r = t; end
    first  = rf ? r : l;
    second = rf ? l : r;
    for (int k = 0; k < 64; k++) begin
      bit is_left;
      raw[k]  = (k < 32) ? first[31-k] : second[63-k];
      is_left = (k < 32) != rf;
      lv[k]   = is_left ? msbj : !msbj;
    end
    for (int k = 0; k < 64; k++)
      d[k] = msbj ? raw[k] : ((k == 0) ? 1'b0 : raw[k-1]);
    q_d.push_back(d);
    q_l.push_back(lv);
    q_r.push_back(req);
  endtask

  // monitor: skip the rise before the first frame, then 64 bits per frame
  int          rises = 0, idx = 0;
  logic        pb = 1'b0;
  logic [63:0] cd, cl;
  always @(negedge clk) begin
    if (!en) begin
      rises = 0;
      idx   = 0;
    end else if (bclk && !pb) begin
      rises++;
      if (rises > 1) begin
        cd[idx] = sdata;
        cl[idx] = lrclk;
        idx++;
        if (idx == 64) begin
          idx = 0;
          if (q_d.size() > 0) begin
            logic [63:0] ed, el;
            string rq;
            ed = q_d.pop_front();
            el = q_l.pop_front();
            rq = q_r.pop_front();
            check(cd == ed, rq, "frame data", cd, ed);
            check(cl == el, rq, "frame lrclk", cl, el);
          end
        end
      end
    end
    pb = bclk;
  end

  task automatic drv; @(posedge clk); #5; endtask

  task automatic push(input logic [23:0] v);
    drv(); wr = 1'b1; wr_data = v;
    drv(); wr = 1'b0;
  endtask

  task automatic set_div(input logic [9:0] v);
    drv(); div_wr = 1'b1; div_val = v;
    drv(); div_wr = 1'b0;
  endtask

  task automatic clear_unr;
    drv(); clr = 1'b1;
    drv(); clr = 1'b0;
  endtask

  task automatic run;
    drv(); en = 1'b1;
    while (q_d.size() != 0) @(negedge clk);
    drv(); en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_rise;
    logic p;
    p = bclk;
    forever begin
      @(negedge clk);
      if (bclk && !p) break;
      p = bclk;
    end
  endtask

  task automatic period(output int c);
    logic p;
    wait_rise();
    c = 0;
    p = bclk;
    forever begin
      @(negedge clk);
      c++;
      if (bclk && !p) break;
      p = bclk;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [23:0] smp [32];

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    @(negedge clk);
    check(bclk == 1'b0, "R3", "reset bclk", 64'(bclk), 0);
    check(level == 6'd0, "R8", "reset level", 64'(level), 0);
    check(tx_req == 1'b1, "R9", "reset request", 64'(tx_req), 1);
    check(underrun == 1'b0, "R10", "reset underrun", 64'(underrun), 0);
    check({lrclk, sdata} == 2'b00, "R3", "reset lr/data", 64'({lrclk, sdata}), 0);

    // R1 / R2: divider
    set_div(10'd2);
    drv(); en = 1'b1;
    period(c);
    check(c == 6, "R1", "period div=2", 64'(c), 6);
    set_div(10'd600);
    period(c);
    period(c);
    check(c == 6, "R2", "period after div=600", 64'(c), 6);
    set_div(10'd3);
    period(c);
    period(c);
    check(c == 8, "R1", "period div=3", 64'(c), 8);
    drv(); en = 1'b0;
    repeat (2) @(negedge clk);
    check(bclk == 1'b0, "R3", "bclk idle", 64'(bclk), 0);
    check(underrun == 1'b1, "R10", "underrun on empty", 64'(underrun), 1);
    clear_unr();
    @(negedge clk);
    check(underrun == 1'b0, "R10", "underrun cleared", 64'(underrun), 0);
    set_div(10'd1);

    // mono both, MSB-justified, 16 bit, then silence on underrun
    msbj = 1; stereo = 0; route = 2'd0; width = 3'd1; last = 0;
    push(24'h012345);
    push(24'h00ABCD);
    want(24'h012345, 0, 0, "R7");
    want(24'h00ABCD, 0, 0, "R4");
    want(0, 0, 1, "R11");
    run();
    check(underrun == 1'b1, "R10", "underrun after drain", 64'(underrun), 1);
    clear_unr();

    // I2S, right only, 8 bit
    msbj = 0; route = 2'd1; width = 3'd0;
    push(24'hABCDEF);
    want(24'hABCDEF, 0, 0, "R5");
    run(); clear_unr();

    // left only with swap, 20 bit
    msbj = 1; route = 2'd2; swap = 1; width = 3'd3;
    push(24'h5A5A5A);
    want(24'h5A5A5A, 0, 0, "R7");
    run(); clear_unr();

    // left only, right first, 18 bit
    swap = 0; rf = 1; width = 3'd2;
    push(24'h3FFFF1);
    want(24'h3FFFF1, 0, 0, "R6");
    run(); clear_unr();

    // stereo fill, threshold, drop on full, repeat on underrun
    rf = 0; route = 2'd0; stereo = 1; msbj = 0; width = 3'd4; last = 1; thresh = 4'd2;
    for (int i = 0; i < 32; i++) smp[i] = 24'h0A0000 + 24'(i) * 24'h010101;
    for (int i = 0; i < 5; i++) push(smp[i]);
    @(negedge clk);
    check(level == 6'd5, "R8", "level 5", 64'(level), 5);
    check(tx_req == 1'b1, "R9", "request at 5, th=2", 64'(tx_req), 1);
    push(smp[5]);
    @(negedge clk);
    check(tx_req == 1'b0, "R9", "no request at 6, th=2", 64'(tx_req), 0);
    for (int i = 6; i < 32; i++) push(smp[i]);
    push(24'hFFFFFF);
    @(negedge clk);
    check(level == 6'd32, "R8", "level stays 32", 64'(level), 32);
    drv(); thresh = 4'd15;
    @(negedge clk);
    check(tx_req == 1'b0, "R9", "no request at 32, th=15", 64'(tx_req), 0);
    for (int j = 0; j < 16; j++) want(smp[2*j], smp[2*j+1], 0, "R6");
    want(smp[30], smp[31], 0, "R11");
    run();
    check(level == 6'd0, "R8", "drained", 64'(level), 0);
    check(tx_req == 1'b1, "R9", "request when empty", 64'(tx_req), 1);
    check(underrun == 1'b1, "R10", "underrun after stereo", 64'(underrun), 1);
    clear_unr();

    // stereo swap + right first, then starve with one entry
    msbj = 1; swap = 1; rf = 1; width = 3'd3; last = 0;
    push(24'h111111);
    push(24'h0F0F0F);
    push(24'h777777);
    want(24'h111111, 24'h0F0F0F, 0, "R6");
    want(0, 0, 1, "R10");
    run();
    check(level == 6'd1, "R10", "no pop on starve", 64'(level), 1);
    clear_unr();
    stereo = 0; route = 2'd0; swap = 0; rf = 0;
    want(24'h777777, 0, 0, "R7");
    run();
    clear_unr();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule